// File: doc/BRIEF.md
# Single-Cycle Load-Store Processor Core

This block is a 64-bit processor core that retires one instruction per clock edge. It supports eight instructions: register add, subtract, AND and OR, a doubleword load and a doubleword store with a signed offset, compare-and-branch-if-zero, and an unconditional branch. The core holds the program counter, the decoder, a 32-entry register file, the immediate sign extension, the ALU and the next-PC selection. Instruction memory and data memory sit outside the core. Both are read combinationally, and the data memory is written on the clock edge.

A test-mode input disconnects the internal decoder. While it is high, an external 10-bit control word and an external 4-bit ALU code steer the datapath directly, so the datapath can be checked without relying on the decoder. A branch whose offset is -1 re-executes itself on every cycle, and a program uses this as its halt.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and clears all 32 registers to 0.
- R2: ADD (bits[31:21]=10001011000) and SUB (11001011000) write Xn+Xm and Xn-Xm to Xd. The fields are Xm=[20:16], Xn=[9:5] and Xd=[4:0].
- R3: AND (10001010000) and ORR (10101010000) write the bitwise AND and OR of Xn and Xm to Xd.
- R4: LDUR (11111000010) writes the data-memory word at address Xn+sext(bits[20:12]) into Xt=[4:0].
- R5: STUR (11111000000) writes Xt to data memory at address Xn+sext(bits[20:12]). The store-enable pin is high only for this write.
- R6: CBZ (bits[31:24]=10110100) with Xt equal to zero sets the next PC to PC+4+4*sext(bits[23:5]).
- R7: CBZ with a nonzero Xt, and every non-branch instruction, sets the next PC to PC+4.
- R8: B (bits[31:26]=000101) sets the next PC to PC+4+4*sext(bits[25:0]). An offset of -1 keeps the PC fixed on every cycle.
- R9: Register 31 always reads as zero, and a write to it is discarded.
- R10: When test_mode is high, ext_ctrl replaces the decoder output. Its bits from MSB to LSB are: second read register from Xt, ALU B from the immediate, writeback from memory, register write, memory read, memory write, conditional branch, unconditional branch, and ALU op[1:0]. ext_alu replaces the ALU code: 0000 AND, 0001 OR, 0010 add, 0110 subtract, 0111 pass B. A branch taken under test mode uses the ALU zero flag.
- R11: Any other opcode writes no register and no memory, and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_mode | input | 1 | Select external control in place of the decoder |
| ext_ctrl | input | 10 | External main-control word |
| ext_alu | input | 4 | External ALU code |
| imem_addr | output | 64 | Instruction fetch address (the PC) |
| imem_data | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | 64 | Data address (ALU result) |
| dmem_wdata | output | 64 | Store data |
| dmem_we | output | 1 | Data-memory write enable |
| dmem_re | output | 1 | Data-memory read strobe |
| dmem_rdata | input | 64 | Load data at dmem_addr |

## Verification
Register contents are not visible at the ports. A wrong register value shows up only when a later store carries it out, when a load address is built from it, or when a CBZ outcome depends on it. The stimulus therefore biases loads and stores toward register 31 as the base, so that random data memory flows into registers and back out again, and it keeps branch offsets small so that CBZ meets both zero and nonzero registers. The test-mode phase drives arbitrary control words, including combinations the decoder never produces. These reach write-back and branch paths that decoded instructions cannot reach.

// File: rtl/sc_pkg.sv
package sc_pkg;

    // Main-control word; member order fixes the bit order of the external word.
    typedef struct packed {
        logic       rt_src;     // second read port takes [4:0] instead of [20:16]
        logic       alu_imm;    // ALU B operand is the immediate
        logic       wb_mem;     // writeback from memory
        logic       rf_we;      // register write
        logic       mem_rd;     // memory read strobe
        logic       mem_wr;     // memory write
        logic       br_cond;    // branch if zero
        logic       br_uncond;  // always branch
        logic [1:0] alu_op;     // ALU operation class
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int ALUC_W = 4;
    localparam int INSN_W = 32;

    localparam logic [ALUC_W-1:0] ALUC_AND   = 4'b0000;
    localparam logic [ALUC_W-1:0] ALUC_OR    = 4'b0001;
    localparam logic [ALUC_W-1:0] ALUC_ADD   = 4'b0010;
    localparam logic [ALUC_W-1:0] ALUC_SUB   = 4'b0110;
    localparam logic [ALUC_W-1:0] ALUC_PASSB = 4'b0111;

    localparam logic [10:0] OPC_ADD  = 11'b10001011000;
    localparam logic [10:0] OPC_SUB  = 11'b11001011000;
    localparam logic [10:0] OPC_AND  = 11'b10001010000;
    localparam logic [10:0] OPC_ORR  = 11'b10101010000;
    localparam logic [10:0] OPC_LDUR = 11'b11111000010;
    localparam logic [10:0] OPC_STUR = 11'b11111000000;
    localparam logic [7:0]  OPC_CBZ  = 8'b10110100;
    localparam logic [5:0]  OPC_B    = 6'b000101;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [INSN_W-1:0] instr,
    output ctrl_t             ctrl,
    output logic [ALUC_W-1:0] alu_code
);

    logic [10:0] opc_long;
    logic        is_rtype;

    assign opc_long = instr[31:21];
    assign is_rtype = (opc_long == OPC_ADD) || (opc_long == OPC_SUB) ||
                      (opc_long == OPC_AND) || (opc_long == OPC_ORR);

    always_comb begin
        ctrl = '0;
        if (is_rtype) begin
            ctrl.rf_we  = 1'b1;
            ctrl.alu_op = 2'b10;
        end else if (opc_long == OPC_LDUR) begin
            ctrl.alu_imm = 1'b1;
            ctrl.wb_mem  = 1'b1;
            ctrl.rf_we   = 1'b1;
            ctrl.mem_rd  = 1'b1;
        end else if (opc_long == OPC_STUR) begin
            ctrl.rt_src  = 1'b1;
            ctrl.alu_imm = 1'b1;
            ctrl.mem_wr  = 1'b1;
        end else if (instr[31:24] == OPC_CBZ) begin
            ctrl.rt_src  = 1'b1;
            ctrl.br_cond = 1'b1;
            ctrl.alu_op  = 2'b01;
        end else if (instr[31:26] == OPC_B) begin
            ctrl.br_uncond = 1'b1;
        end
    end

    // Second-level ALU decode from the operation class and the opcode.
    always_comb begin
        unique case (ctrl.alu_op)
            2'b00:   alu_code = ALUC_ADD;
            2'b01:   alu_code = ALUC_PASSB;
            default: begin
                unique case (opc_long)
                    OPC_SUB: alu_code = ALUC_SUB;
                    OPC_AND: alu_code = ALUC_AND;
                    OPC_ORR: alu_code = ALUC_OR;
                    default: alu_code = ALUC_ADD;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int XLEN = 64,
    parameter int NREG = 32,
    localparam int AW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   raddr_a,
    input  logic [AW-1:0]   raddr_b,
    output logic [XLEN-1:0] rdata_a,
    output logic [XLEN-1:0] rdata_b,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata
);

    localparam logic [AW-1:0] ZR = AW'(NREG - 1);

    logic [NREG-1:0][XLEN-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we && (waddr != ZR)) begin
            regs_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata_a = (raddr_a == ZR) ? '0 : regs_q[raddr_a];
    assign rdata_b = (raddr_b == ZR) ? '0 : regs_q[raddr_b];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (we && (waddr != ZR)) |=> (regs_q[$past(waddr)] == $past(wdata))); // R2

    AST_ZERO_REG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (we && (waddr == ZR)) |=> (regs_q[ZR] == '0)); // R9

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]   opa,
    input  logic [XLEN-1:0]   opb,
    input  logic [ALUC_W-1:0] code,
    output logic [XLEN-1:0]   res,
    output logic              zero
);

    always_comb begin
        unique case (code)
            ALUC_AND:   res = opa & opb;
            ALUC_OR:    res = opa | opb;
            ALUC_ADD:   res = opa + opb;
            ALUC_SUB:   res = opa - opb;
            ALUC_PASSB: res = opb;
            default:    res = '0;
        endcase
    end

    assign zero = (res == '0);

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NREG = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              test_mode,
    input  logic [CTRL_W-1:0] ext_ctrl,
    input  logic [ALUC_W-1:0] ext_alu,
    output logic [XLEN-1:0]   imem_addr,
    input  logic [INSN_W-1:0] imem_data,
    output logic [XLEN-1:0]   dmem_addr,
    output logic [XLEN-1:0]   dmem_wdata,
    output logic              dmem_we,
    output logic              dmem_re,
    input  logic [XLEN-1:0]   dmem_rdata
);

    localparam int AW = $clog2(NREG);
    localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_st_t;

    core_st_t st_d, st_q;

    ctrl_t             dec_ctrl, ctl;
    logic [ALUC_W-1:0] dec_alu, alu_code;
    logic [AW-1:0]     rn, rm, rt, rb_sel;
    logic [XLEN-1:0]   rd_a, rd_b, imm_ext, alu_b, alu_res, wb_data;
    logic [XLEN-1:0]   pc_plus4, br_target;
    logic              alu_zero, take_br;

    sc_decode u_dec (
        .instr    (imem_data),
        .ctrl     (dec_ctrl),
        .alu_code (dec_alu)
    );

    // Test-mode override of both control levels.
    assign ctl      = test_mode ? ctrl_t'(ext_ctrl) : dec_ctrl;
    assign alu_code = test_mode ? ext_alu : dec_alu;

    assign rn     = imem_data[9:5];
    assign rm     = imem_data[20:16];
    assign rt     = imem_data[4:0];
    assign rb_sel = ctl.rt_src ? rt : rm;

    // Immediate format chosen by the opcode pattern.
    always_comb begin
        if (imem_data[31:26] == OPC_B) begin
            imm_ext = {{(XLEN-26){imem_data[25]}}, imem_data[25:0]};
        end else if (imem_data[31:24] == OPC_CBZ) begin
            imm_ext = {{(XLEN-19){imem_data[23]}}, imem_data[23:5]};
        end else begin
            imm_ext = {{(XLEN-9){imem_data[20]}}, imem_data[20:12]};
        end
    end

    sc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .raddr_a (rn),
        .raddr_b (rb_sel),
        .rdata_a (rd_a),
        .rdata_b (rd_b),
        .we      (ctl.rf_we),
        .waddr   (rt),
        .wdata   (wb_data)
    );

    assign alu_b = ctl.alu_imm ? imm_ext : rd_b;

    sc_alu #(.XLEN(XLEN)) u_alu (
        .opa  (rd_a),
        .opb  (alu_b),
        .code (alu_code),
        .res  (alu_res),
        .zero (alu_zero)
    );

    assign wb_data = ctl.wb_mem ? dmem_rdata : alu_res;

    // Next-PC selection: the target is relative to the incremented PC.
    assign pc_plus4  = st_q.pc + PC_STEP;
    assign br_target = pc_plus4 + (imm_ext << 2);
    assign take_br   = ctl.br_uncond || (ctl.br_cond && alu_zero);

    always_comb begin
        st_d    = st_q;
        st_d.pc = take_br ? br_target : pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign imem_addr  = st_q.pc;
    assign dmem_addr  = alu_res;
    assign dmem_wdata = rd_b;
    assign dmem_we    = ctl.mem_wr;
    assign dmem_re    = ctl.mem_rd;

    AST_PC_CLEARED: assert property (@(posedge clk)
        $fell(rst) |-> (st_q.pc == '0)); // R1

    AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
        (!ctl.br_uncond && !(ctl.br_cond && alu_zero))
        |=> (st_q.pc == $past(st_q.pc) + PC_STEP)); // R7

    AST_CBZ_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (ctl.br_cond && alu_zero)
        |=> (st_q.pc == $past(st_q.pc) + PC_STEP + ($past(imm_ext) << 2))); // R6

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        ctl.br_uncond
        |=> (st_q.pc == $past(st_q.pc) + PC_STEP + ($past(imm_ext) << 2))); // R8

    AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (st_q.pc[1:0] == 2'b00)); // R8

    AST_TEST_STORE: assert property (@(posedge clk) disable iff (rst)
        test_mode |-> (dmem_we == ext_ctrl[4])); // R10

endmodule

// File: tb/sc_core_bench.sv
`timescale 1ns/1ps
module sc_core_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        test_mode = 1'b0;
    logic [9:0]  ext_ctrl = '0;
    logic [3:0]  ext_alu = '0;
    logic [63:0] imem_addr, dmem_addr, dmem_wdata, dmem_rdata;
    logic [31:0] imem_data;
    logic        dmem_we, dmem_re;

    logic [31:0] imem [64];
    logic [63:0] dmem [64];
    logic [63:0] m_mem [64];
    logic [63:0] m_regs [32];
    logic [63:0] m_pc;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign imem_data  = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[8:3]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[8:3]] <= dmem_wdata;
    end

    sc_core u_sc_core (
        .clk(clk), .rst(rst), .test_mode(test_mode), .ext_ctrl(ext_ctrl),
        .ext_alu(ext_alu), .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
        .dmem_re(dmem_re), .dmem_rdata(dmem_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Encoders
    function automatic logic [31:0] enc_r(logic [10:0] op, int m, int n, int d);
        return {op, 5'(m), 6'd0, 5'(n), 5'(d)};
    endfunction
    function automatic logic [31:0] enc_d(logic [10:0] op, int off, int n, int t);
        return {op, 9'(off), 2'b00, 5'(n), 5'(t)};
    endfunction
    function automatic logic [31:0] enc_cb(int off, int t);
        return {8'b10110100, 19'(off), 5'(t)};
    endfunction
    function automatic logic [31:0] enc_b(int off);
        return {6'b000101, 26'(off)};
    endfunction

    // Expected control per requirements: {ctrl[9:0], alu[3:0]}
    function automatic logic [13:0] exp_ctrl(logic [31:0] i);
        case (i[31:21])
            11'b10001011000: return {10'b0001000010, 4'b0010};
            11'b11001011000: return {10'b0001000010, 4'b0110};
            11'b10001010000: return {10'b0001000010, 4'b0000};
            11'b10101010000: return {10'b0001000010, 4'b0001};
            11'b11111000010: return {10'b0111100000, 4'b0010};
            11'b11111000000: return {10'b1100010000, 4'b0010};
            default: ;
        endcase
        if (i[31:24] == 8'b10110100) return {10'b1000001001, 4'b0111};
        if (i[31:26] == 6'b000101)   return {10'b0000000100, 4'b0010};
        return {10'b0, 4'b0010};
    endfunction

    function automatic logic [63:0] exp_imm(logic [31:0] i);
        if (i[31:26] == 6'b000101) return {{38{i[25]}}, i[25:0]};
        if (i[31:24] == 8'b10110100) return {{45{i[23]}}, i[23:5]};
        return {{55{i[20]}}, i[20:12]};
    endfunction

    function automatic logic [63:0] exp_alu(logic [3:0] c, logic [63:0] a, logic [63:0] b);
        case (c)
            4'b0000: return a & b;
            4'b0001: return a | b;
            4'b0010: return a + b;
            4'b0110: return a - b;
            4'b0111: return b;
            default: return 64'd0;
        endcase
    endfunction

    function automatic string req_of(logic [31:0] i, bit tm);
        if (tm) return "R10";
        case (i[31:21])
            11'b10001011000, 11'b11001011000: return "R2";
            11'b10001010000, 11'b10101010000: return "R3";
            11'b11111000010: return "R4";
            11'b11111000000: return "R5";
            default: ;
        endcase
        if (i[31:24] == 8'b10110100) return "R6";
        if (i[31:26] == 6'b000101) return "R8";
        return "R11";
    endfunction

    function automatic logic [63:0] rreg(logic [4:0] r);
        return (r == 5'd31) ? 64'd0 : m_regs[r];
    endfunction

    task automatic model_reset();
        m_pc = 64'd0;
        foreach (m_regs[k]) m_regs[k] = 64'd0;
        foreach (dmem[k]) m_mem[k] = dmem[k];
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        #1;
        chk(imem_addr == 64'd0, "R1", "pc after reset", imem_addr, 64'd0);
    endtask

    // Step one cycle: compare ports with the model, then advance the model.
    task automatic step(bit tm);
        logic [31:0] ins;
        logic [13:0] cw;
        logic [9:0]  c;
        logic [3:0]  ac;
        logic [63:0] a, b, imm, res, wb, ld;
        string rq;
        ins = imem[m_pc[7:2]];
        if (tm) begin
            ext_ctrl = 10'($urandom);
            case ($urandom % 5)
                0: ext_alu = 4'b0000;
                1: ext_alu = 4'b0001;
                2: ext_alu = 4'b0010;
                3: ext_alu = 4'b0110;
                default: ext_alu = 4'b0111;
            endcase
            c = ext_ctrl; ac = ext_alu;
        end else begin
            cw = exp_ctrl(ins); c = cw[13:4]; ac = cw[3:0];
        end
        test_mode = tm;
        #1;
        rq = req_of(ins, tm);
        chk(imem_addr == m_pc, rq, "pc", imem_addr, m_pc);
        imm = exp_imm(ins);
        a   = rreg(ins[9:5]);
        b   = rreg(c[9] ? ins[4:0] : ins[20:16]);
        res = exp_alu(ac, a, c[8] ? imm : b);
        ld  = m_mem[res[8:3]];
        wb  = c[7] ? ld : res;
        chk(dmem_we == c[4], rq, "store enable", 64'(dmem_we), 64'(c[4]));
        chk(dmem_re == c[5], rq, "read strobe", 64'(dmem_re), 64'(c[5]));
        if (c[4]) begin
            chk(dmem_addr == res, rq, "store addr", dmem_addr, res);
            chk(dmem_wdata == b, (ins[4:0] == 5'd31 && c[9]) ? "R9" : rq,
                "store data", dmem_wdata, b);
            m_mem[res[8:3]] = b;
        end
        if (c[6] && ins[4:0] != 5'd31) m_regs[ins[4:0]] = wb;
        if (c[2] || (c[3] && res == 64'd0)) m_pc = m_pc + 64'd4 + (imm << 2);
        else m_pc = m_pc + 64'd4;
        @(negedge clk);
    endtask

    function automatic logic [31:0] rand_ins();
        int r = $urandom % 100;
        int n = ($urandom % 2) ? 31 : int'($urandom % 32);
        if (r < 10) return enc_r(11'b10001011000, $urandom%32, $urandom%32, $urandom%32);
        if (r < 20) return enc_r(11'b11001011000, $urandom%32, $urandom%32, $urandom%32);
        if (r < 27) return enc_r(11'b10001010000, $urandom%32, $urandom%32, $urandom%32);
        if (r < 34) return enc_r(11'b10101010000, $urandom%32, $urandom%32, $urandom%32);
        if (r < 56) return enc_d(11'b11111000010, $urandom%512, n, $urandom%32);
        if (r < 72) return enc_d(11'b11111000000, $urandom%512, n, $urandom%32);
        if (r < 84) return enc_cb(int'($urandom % 17) - 8, $urandom%32);
        if (r < 92) return enc_b(int'($urandom % 17) - 8);
        return $urandom;
    endfunction

    initial begin
        logic [63:0] d1, d2, keep3;
        void'($urandom(32'd20251));
        // Directed program
        foreach (imem[k]) imem[k] = 32'd0;
        foreach (dmem[k]) dmem[k] = {$urandom, $urandom} | 64'd1;
        d1 = dmem[1]; d2 = dmem[2]; keep3 = dmem[3];
        imem[0]  = enc_d(11'b11111000010, 8, 31, 1);
        imem[1]  = enc_d(11'b11111000010, 16, 31, 2);
        imem[2]  = enc_r(11'b10001011000, 2, 1, 3);
        imem[3]  = enc_r(11'b10001011000, 2, 1, 31);
        imem[4]  = enc_d(11'b11111000000, 0, 31, 31);
        imem[5]  = enc_cb(3, 31);
        imem[6]  = enc_d(11'b11111000000, 24, 31, 3);
        imem[7]  = enc_d(11'b11111000000, 24, 31, 3);
        imem[8]  = enc_d(11'b11111000000, 24, 31, 3);
        imem[9]  = enc_cb(5, 1);
        imem[10] = enc_d(11'b11111000000, 32, 31, 3);
        imem[11] = enc_b(-1);
        do_reset();
        for (int k = 0; k < 20; k++) step(1'b0);
        chk(imem_addr == 64'd44, "R8", "halt pc", imem_addr, 64'd44);
        chk(dmem[0] == 64'd0, "R9", "zero reg store", dmem[0], 64'd0);
        chk(dmem[3] == keep3, "R6", "skipped store", dmem[3], keep3);
        chk(dmem[4] == d1 + d2, "R7", "fallthrough store", dmem[4], d1 + d2);

        // Random decoded programs (R1 also covered: registers must restart at zero)
        for (int p = 0; p < 4; p++) begin
            foreach (imem[k]) imem[k] = rand_ins();
            foreach (dmem[k]) dmem[k] = {$urandom, $urandom};
            do_reset();
            for (int k = 0; k < 1500; k++) step(1'b0);
        end

        // Test mode with arbitrary control words (R10)
        for (int p = 0; p < 2; p++) begin
            foreach (imem[k]) imem[k] = rand_ins();
            foreach (dmem[k]) dmem[k] = {$urandom, $urandom};
            do_reset();
            for (int k = 0; k < 1500; k++) step(1'b1);
            test_mode = 1'b0;
        end

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule